// File: doc/BRIEF.md
# Flash-to-FPGA Configuration Loader

This block brings up a target FPGA from a byte-wide parallel NOR flash after power-up or reset. The flash is taken to be in its array-read state, so it is read like a plain ROM and no command cycles are issued. The loader first pulses the target's program input low, then waits for the target's initialisation-ready line to go high. It then walks through the flash image one byte per read, starting at a parameterised base address that lies above a reserved status area at the bottom of the flash. For each byte it drives the address, holds chip-enable and output-enable low for a fixed number of clock ticks, captures the byte, and writes it to the target's slave parallel configuration port with a one-cycle write strobe.

The target's busy line holds a byte at the port until the target can accept it. When the target reports configuration done, the loader stops. It then drops its bus-ownership output, so the address and control pads can be tri-stated and another master can take over the flash. If no done indication arrives within a maximum byte count, the loader raises an error flag and releases the bus in the same way. The loader is meant to run from a clock of about 20 MHz. At that rate the default five-tick access window is longer than 110 ns. The flash is always read 8 bits at a time, with no page reads.

Top module: `cfg_loader`

## Requirements
- R1: While reset is high and on the first cycles after reset, `tgt_prog_n`, `fl_ce_n`, `fl_oe_n` and `tgt_wr_n` are high, `bus_own` is high and `cfg_err` is low.
- R2: After reset, `tgt_prog_n` goes low for exactly PROG_CYC consecutive cycles, once.
- R3: No flash read starts (`fl_ce_n` low) while `tgt_prog_n` is low or `tgt_init_n` is low; the first read waits for `tgt_init_n` to be high.
- R4: The first flash read uses address BASE_ADDR, and each later read uses the previous address plus one. The address is stable throughout a read.
- R5: Every read holds `fl_ce_n` and `fl_oe_n` low together for exactly WAIT_CYC consecutive cycles.
- R6: After each read, the byte present on `fl_data_i` at the end of that read appears on `tgt_data`, and `tgt_wr_n` is low for exactly one cycle to write it. There is one strobe per read.
- R7: While `tgt_busy` is high, no write strobe is issued and the pending byte is held. The strobe follows in the cycle after busy is sampled low.
- R8: If `tgt_done` is high when a byte's strobe completes, the loader stops. `bus_own` goes low and stays low until reset, no further reads or strobes occur, and `cfg_err` stays low.
- R9: If MAX_BYTES strobes complete without `tgt_done`, `cfg_err` goes high, `bus_own` goes low, and exactly MAX_BYTES bytes have been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, about 20 MHz |
| rst | input | 1 | Synchronous active-high reset; restarts the whole sequence |
| fl_addr | output | ADDR_W | Flash byte address; valid while `bus_own` is high |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_data_i | input | 8 | Flash read data |
| bus_own | output | 1 | High while the loader drives the flash pads; low means tri-state them |
| tgt_prog_n | output | 1 | Target program/reset request, active low |
| tgt_init_n | input | 1 | Target ready for configuration data when high |
| tgt_busy | input | 1 | Target cannot accept a byte while high |
| tgt_done | input | 1 | Target reports configuration complete |
| tgt_data | output | 8 | Configuration byte to the target port |
| tgt_wr_n | output | 1 | Target port write strobe, active low, one cycle per byte |
| cfg_err | output | 1 | Byte limit reached without done |

## Verification
The hardest case to reach is a byte held at the target port while busy is high, after the flash read has already ended. That is the only place where the data latch, the strobe and the address counter can slip against each other. The bench target model raises busy in the last cycle of each flash access and keeps it high for three cycles. Every byte therefore waits in the port state, and the bench checks that no strobe appears under busy and that each byte matches the address read. A second hard point is the byte-limit stop. It needs a target that never reports done, so the bench runs with a small MAX_BYTES and counts the strobes up to the error.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_PROG = 4'd1,   // target program pulse
        ST_INIT = 4'd2,   // wait for target ready
        ST_READ = 4'd3,   // flash access window
        ST_PORT = 4'd4,   // byte waits for target not busy
        ST_STRB = 4'd5,   // write strobe cycle
        ST_NEXT = 4'd6,   // advance address, test end conditions
        ST_HALT = 4'd7,   // target configured, bus released
        ST_FAIL = 4'd8    // byte limit reached, bus released
    } seq_st_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic wr_n;
        logic prog_n;
        logic own;
        logic err;
    } bus_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic bus_ctl_t ctl_of(input seq_st_t s);
        bus_ctl_t c;
        c.ce_n   = (s != ST_READ);
        c.oe_n   = (s != ST_READ);
        c.wr_n   = (s != ST_STRB);
        c.prog_n = (s != ST_PROG);
        c.own    = (s != ST_HALT) && (s != ST_FAIL);
        c.err    = (s == ST_FAIL);
        return c;
    endfunction

endpackage

// File: rtl/cfg_tick_timer.sv
module cfg_tick_timer #(
    parameter int unsigned TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - TW'(1);
    end

    assign zero = (cnt_q == '0);

    // R5: an expired timer stays expired until reloaded
    a_r5_timer_parks: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
    parameter int unsigned          ADDR_W    = 24,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = '0,
    parameter int unsigned          MAX_BYTES = 16,
    parameter int unsigned          CW        = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [CW-1:0] LAST_CNT = CW'(MAX_BYTES - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [CW-1:0]     cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            addr_q <= BASE_ADDR;
            cnt_q  <= '0;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign addr = addr_q;
    assign last = (cnt_q == LAST_CNT);

    // R9: byte count never passes the limit
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAX_BYTES));

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_loader_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 5,
    parameter int unsigned PROG_CYC = 8,
    parameter int unsigned TW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tmr_zero,
    input  logic          init_ok,
    input  logic          busy,
    input  logic          done,
    input  logic          last,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          restart,
    output logic          step,
    output logic          capture,
    output bus_ctl_t      ctl
);
    localparam logic [TW-1:0] PROG_LD = TW'(PROG_CYC - 1);
    localparam logic [TW-1:0] WAIT_LD = TW'(WAIT_CYC - 1);

    seq_st_t  st_q, st_n;
    bus_ctl_t ctl_q;

    always_comb begin
        st_n     = st_q;
        tmr_load = 1'b0;
        tmr_val  = WAIT_LD;
        restart  = 1'b0;
        step     = 1'b0;
        capture  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                restart  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = PROG_LD;
                st_n     = ST_PROG;
            end
            ST_PROG: if (tmr_zero) st_n = ST_INIT;
            ST_INIT: if (init_ok) begin
                tmr_load = 1'b1;
                st_n     = ST_READ;
            end
            ST_READ: if (tmr_zero) begin
                capture = 1'b1;
                st_n    = ST_PORT;
            end
            ST_PORT: if (!busy) st_n = ST_STRB;
            ST_STRB: st_n = ST_NEXT;
            ST_NEXT: begin
                step = 1'b1;
                if (done)
                    st_n = ST_HALT;
                else if (last)
                    st_n = ST_FAIL;
                else begin
                    tmr_load = 1'b1;
                    st_n     = ST_READ;
                end
            end
            ST_HALT: st_n = ST_HALT;
            ST_FAIL: st_n = ST_FAIL;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ctl_q <= ctl_of(ST_IDLE);
        end else begin
            st_q  <= st_n;
            ctl_q <= ctl_of(st_n);
        end
    end

    assign ctl = ctl_q;

    // R2: program pulse only comes out of the idle/program phase
    a_r2_prog_origin: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.prog_n) |-> $past(st_q) == ST_IDLE);

    // R8: terminal states are never left without reset
    a_r8_terminal_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALT || st_q == ST_FAIL) |=> $stable(st_q));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h002000,
    parameter int unsigned       WAIT_CYC  = 5,
    parameter int unsigned       PROG_CYC  = 8,
    parameter int unsigned       MAX_BYTES = 1048576
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    input  logic [7:0]        fl_data_i,
    output logic              bus_own,
    output logic              tgt_prog_n,
    input  logic              tgt_init_n,
    input  logic              tgt_busy,
    input  logic              tgt_done,
    output logic [7:0]        tgt_data,
    output logic              tgt_wr_n,
    output logic              cfg_err
);
    localparam int unsigned TW = cnt_width(max2(WAIT_CYC, PROG_CYC));
    localparam int unsigned CW = cnt_width(MAX_BYTES);

    logic              tmr_load, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic              restart, step, capture, last;
    bus_ctl_t          ctl;
    logic [BYTE_W-1:0] byte_q;

    cfg_tick_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    cfg_addr_gen #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .MAX_BYTES (MAX_BYTES),
        .CW        (CW)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step    (step),
        .addr    (fl_addr),
        .last    (last)
    );

    cfg_seq_ctrl #(
        .WAIT_CYC (WAIT_CYC),
        .PROG_CYC (PROG_CYC),
        .TW       (TW)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tmr_zero (tmr_zero),
        .init_ok  (tgt_init_n),
        .busy     (tgt_busy),
        .done     (tgt_done),
        .last     (last),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .restart  (restart),
        .step     (step),
        .capture  (capture),
        .ctl      (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst)
            byte_q <= '0;
        else if (capture)
            byte_q <= fl_data_i;
    end

    assign tgt_data   = byte_q;
    assign fl_ce_n    = ctl.ce_n;
    assign fl_oe_n    = ctl.oe_n;
    assign tgt_wr_n   = ctl.wr_n;
    assign tgt_prog_n = ctl.prog_n;
    assign bus_own    = ctl.own;
    assign cfg_err    = ctl.err;

    // R3: no flash access during the program pulse
    a_r3_no_read_in_prog: assert property (@(posedge clk) disable iff (rst)
        !fl_ce_n |-> tgt_prog_n);

    // R4: address steady across a read
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!fl_oe_n && $past(!fl_oe_n)) |-> $stable(fl_addr));

    // R5: output enable only together with chip enable
    a_r5_oe_with_ce: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_ce_n);

    // R6: strobe is a single cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !tgt_wr_n |=> tgt_wr_n);

    // R6: byte steady while strobing
    a_r6_byte_stable: assert property (@(posedge clk) disable iff (rst)
        !tgt_wr_n |-> $stable(tgt_data));

    // R7: strobe never follows a busy sample
    a_r7_strobe_not_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(tgt_wr_n) |-> !$past(tgt_busy));

    // R8: release is final until reset
    a_r8_release_final: assert property (@(posedge clk) disable iff (rst)
        !bus_own |=> !bus_own);

    // R9: error implies release
    a_r9_err_released: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !bus_own);

endmodule

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;

    localparam int unsigned    AW    = 16;
    localparam logic [AW-1:0]  BASE  = 16'h0040;
    localparam int             WAITC = 5;
    localparam int             PROGC = 4;
    localparam int             MAXB  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] fl_addr;
    logic          fl_ce_n, fl_oe_n, bus_own, tgt_prog_n, tgt_wr_n, cfg_err;
    logic [7:0]    fl_data_i, tgt_data;
    logic          tgt_init_n = 1'b1;
    logic          tgt_busy   = 1'b0;
    logic          tgt_done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [7:0] fdat(input logic [AW-1:0] a);
        return a[7:0] ^ {a[3:0], a[7:4]} ^ a[15:8] ^ 8'h3C;
    endfunction

    assign fl_data_i = fdat(fl_addr);

    cfg_loader #(
        .ADDR_W    (AW),
        .BASE_ADDR (BASE),
        .WAIT_CYC  (WAITC),
        .PROG_CYC  (PROGC),
        .MAX_BYTES (MAXB)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .fl_addr    (fl_addr),
        .fl_ce_n    (fl_ce_n),
        .fl_oe_n    (fl_oe_n),
        .fl_data_i  (fl_data_i),
        .bus_own    (bus_own),
        .tgt_prog_n (tgt_prog_n),
        .tgt_init_n (tgt_init_n),
        .tgt_busy   (tgt_busy),
        .tgt_done   (tgt_done),
        .tgt_data   (tgt_data),
        .tgt_wr_n   (tgt_wr_n),
        .cfg_err    (cfg_err)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // scenario knobs and observation counters
    int done_after, init_delay, init_cnt, busy_cnt;
    bit busy_mode, first_seen;
    int nbytes, prog_cnt, oe_run, runs, bad_run, early, addr_err, data_err;
    int busy_viol, stall, post_act;
    logic [AW-1:0] last_addr;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // target and flash observer, acting between clock edges
    always @(negedge clk) if (!rst) begin
        if (!tgt_prog_n) prog_cnt++;
        if (!fl_ce_n && (!tgt_init_n || !tgt_prog_n)) early++;
        if (!fl_oe_n) begin
            if (fl_ce_n) bad_run++;
            if (oe_run == 0) begin
                if (!first_seen) begin
                    if (fl_addr != BASE) addr_err++;
                end else if (fl_addr != last_addr + 16'd1) addr_err++;
                first_seen = 1;
                last_addr  = fl_addr;
            end else if (fl_addr != last_addr) addr_err++;
            oe_run++;
            if (busy_mode && oe_run == WAITC) begin
                tgt_busy = 1'b1;
                busy_cnt = 3;
            end
        end else if (oe_run != 0) begin
            runs++;
            if (oe_run != WAITC) bad_run++;
            oe_run = 0;
        end
        if (!tgt_wr_n) begin
            if (tgt_busy) busy_viol++;
            if (tgt_data != fdat(last_addr)) data_err++;
            nbytes++;
            if (done_after != 0 && nbytes == done_after) tgt_done = 1'b1;
        end
        if (!bus_own && (!tgt_wr_n || !fl_oe_n || !fl_ce_n)) post_act++;
        if (tgt_busy && fl_oe_n && tgt_wr_n) stall++;
        if (busy_cnt > 0 && fl_oe_n) begin
            busy_cnt--;
            if (busy_cnt == 0) tgt_busy = 1'b0;
        end
        if (!tgt_prog_n) begin
            tgt_init_n = 1'b0;
            init_cnt   = init_delay;
        end else if (!tgt_init_n) begin
            if (init_cnt == 0) tgt_init_n = 1'b1;
            else init_cnt--;
        end
    end

    task automatic do_reset(input int d_after, input int i_delay, input bit bmode);
        @(negedge clk);
        rst = 1'b1;
        tgt_done = 1'b0; tgt_busy = 1'b0; tgt_init_n = 1'b1; busy_cnt = 0;
        done_after = d_after; init_delay = i_delay; busy_mode = bmode;
        nbytes = 0; prog_cnt = 0; oe_run = 0; runs = 0; bad_run = 0; early = 0;
        addr_err = 0; data_err = 0; busy_viol = 0; stall = 0; post_act = 0;
        first_seen = 0; last_addr = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tgt_prog_n && fl_ce_n && fl_oe_n && tgt_wr_n, "R1 strobes idle in reset",
            {tgt_prog_n, fl_ce_n, fl_oe_n, tgt_wr_n}, 15);
        chk(bus_own === 1'b1 && cfg_err === 1'b0, "R1 own/err in reset",
            {bus_own, cfg_err}, 2);
        rst = 1'b0;
        @(negedge clk);
        chk(fl_ce_n && tgt_wr_n && bus_own && !cfg_err, "R1 first cycle after reset",
            {fl_ce_n, tgt_wr_n, bus_own, cfg_err}, 14);
    endtask

    task automatic wait_release();
        for (int k = 0; k < 3000 && bus_own; k++) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_basic();
        do_reset(6, 3, 0);
        wait_release();
        chk(prog_cnt == PROGC, "R2 program pulse width", prog_cnt, PROGC);
        chk(early == 0, "R3 no read before init", early, 0);
        chk(addr_err == 0 && first_seen, "R4 address sequence", addr_err, 0);
        chk(bad_run == 0 && runs == 6, "R5 access window", runs - bad_run, 6);
        chk(data_err == 0, "R6 byte matches flash", data_err, 0);
        chk(nbytes == 6, "R6 strobe count", nbytes, 6);
        chk(!bus_own && !cfg_err, "R8 released without error", {bus_own, cfg_err}, 0);
        chk(post_act == 0 && fl_ce_n && fl_oe_n, "R8 quiet after release", post_act, 0);
    endtask

    task automatic t_slow_init();
        do_reset(3, 25, 0);
        wait_release();
        chk(early == 0, "R3 long init hold", early, 0);
        chk(prog_cnt == PROGC, "R2 single pulse", prog_cnt, PROGC);
        chk(nbytes == 3 && data_err == 0, "R6 bytes after slow init", nbytes, 3);
    endtask

    task automatic t_busy();
        do_reset(5, 0, 1);
        wait_release();
        chk(busy_viol == 0, "R7 no strobe under busy", busy_viol, 0);
        chk(stall == 15, "R7 byte held three cycles each", stall, 15);
        chk(data_err == 0 && nbytes == 5, "R7 held bytes correct", data_err, 0);
        chk(addr_err == 0, "R4 addresses with stalls", addr_err, 0);
        chk(!bus_own && !cfg_err, "R8 release after busy run", {bus_own, cfg_err}, 0);
    endtask

    task automatic t_first_byte_done();
        do_reset(1, 0, 0);
        wait_release();
        chk(nbytes == 1, "R8 stop after one byte", nbytes, 1);
        chk(post_act == 0 && !bus_own, "R8 no activity after done", post_act, 0);
    endtask

    task automatic t_limit();
        do_reset(0, 2, 0);
        wait_release();
        chk(cfg_err === 1'b1, "R9 error raised", cfg_err, 1);
        chk(!bus_own, "R9 bus released", bus_own, 0);
        chk(nbytes == MAXB, "R9 byte count at limit", nbytes, MAXB);
        chk(data_err == 0 && addr_err == 0, "R9 image bytes correct", data_err + addr_err, 0);
        chk(post_act == 0, "R9 quiet after error", post_act, 0);
        do_reset(2, 0, 0);   // R1: reset clears the error
        wait_release();
        chk(!cfg_err && nbytes == 2, "R1 restart after error", nbytes, 2);
    endtask

    initial begin
        t_basic();
        t_slow_init();
        t_busy();
        t_first_byte_done();
        t_limit();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule